// File: doc/BRIEF.md
# USB Upstream Suspend and Wake Controller

This block decides when an isolated USB port drops into its low-power suspend state and when it comes back. It watches the synchronized upstream line state and counts how long the bus sits in the idle (J) state, using a 1 MHz tick. Once the idle period runs past a programmable limit, it raises a suspend flag that other logic uses as a power gate.

While suspended, the block looks for any reason to wake: a change of the upstream line state, a connection change reported by the downstream speed detector, or resume signalling coming from the downstream side. On any of these it drops the suspend flag at once. It then holds a wake-ready flag low for a settle delay before the rest of the port may rely on it. Connection changes are passed on in every state, so attach and detach keep being reported while the port sleeps. An enable input held low returns everything to the reset state.

Top module: `usbsw_ctrl`

## Requirements
- R1: `line_state` uses the encoding 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 SE1. Only J counts as idle. Each `tick_us` pulse seen while the line is J advances an idle count. Any other line state (SE0, K or SE1) clears that count to zero.
- R2: `suspend` rises on the clock edge after the edge on which the idle count reaches IDLE_US+1 ticks. In other words, the bus must stay idle strictly longer than IDLE_US microseconds.
- R3: While `suspend` is high, a line state that differs from the one sampled on the previous edge clears `suspend` on the next edge.
- R4: While `suspend` is high, a `conn_change` pulse or a `dn_resume` pulse clears `suspend` on the next edge.
- R5: `conn_event` is `conn_change` delayed by one clock, in every power state while enabled. This includes suspend.
- R6: After leaving suspend through R3 or R4, `wake_ready` stays low. It rises on the edge after SETTLE_US ticks have been counted since the exit.
- R7: The time from leaving suspend to `wake_ready` rising never exceeds RECOVERY_US ticks.
- R8: While `enable` is low, on the next edge `suspend` is 0, `wake_ready` is 1 and `conn_event` is 0. Both counters are cleared, so a full idle period is needed again after `enable` returns.
- R9: After reset, `suspend` is 0, `wake_ready` is 1 and `conn_event` is 0.
- R10: Wake causes (`conn_change`, `dn_resume`, line changes) have no effect on the power state while the port is active or settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Low holds the controller in its reset state |
| line_state | input | 2 | Synchronized upstream line state (SE0/J/K/SE1) |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| conn_change | input | 1 | Downstream attach/detach pulse from the speed detector |
| dn_resume | input | 1 | Downstream resume signalling seen |
| suspend | output | 1 | Port is in suspend |
| wake_ready | output | 1 | Port is awake and settled |
| conn_event | output | 1 | Registered connection-change report |

## Verification
The bench builds the block with IDLE_US = 20 and SETTLE_US = 3, and pulses the tick every fifth clock. With these values a suspend entry takes about a hundred cycles instead of several thousand. That makes it possible to reach suspend many times in one run and to exercise each wake cause in turn. The short idle limit also lets the bench interrupt an idle stretch just before it expires. The small settle value lets the bench step through the whole settle window and still stay far below the recovery bound.

// File: rtl/usbsw_pkg.sv
package usbsw_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'b00,
        PS_SUSPEND = 2'b01,
        PS_SETTLE  = 2'b10
    } pwr_t;
endpackage

// File: rtl/usbsw_idle_timer.sv
module usbsw_idle_timer
    import usbsw_pkg::*;
#(
    parameter int unsigned IDLE_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tick,
    input  logic [1:0] line,
    output logic       expired
);
    localparam int unsigned LIMIT = IDLE_US + 1;
    localparam int W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } idle_t;

    idle_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear || (line != LS_J)) begin
            nxt_d.cnt = '0;
        end else if (tick && (cur_q.cnt != W'(LIMIT))) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign expired = (cur_q.cnt == W'(LIMIT));
endmodule

// File: rtl/usbsw_settle_timer.sv
module usbsw_settle_timer #(
    parameter int unsigned SETTLE_US = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(SETTLE_US + 2);

    typedef struct packed {
        logic [W-1:0] cnt;
    } settle_t;

    settle_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!run) begin
            nxt_d.cnt = '0;
        end else if (tick && (cur_q.cnt != W'(SETTLE_US))) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign done = (cur_q.cnt == W'(SETTLE_US));
endmodule

// File: rtl/usbsw_wake_detect.sv
module usbsw_wake_detect
    import usbsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] line,
    input  logic       conn_change,
    input  logic       dn_resume,
    output logic       wake,
    output logic       conn_event
);
    typedef struct packed {
        logic [1:0] prev;
        logic       conn;
    } wake_t;

    wake_t cur_q, nxt_d;

    always_comb begin
        nxt_d.prev = line;
        nxt_d.conn = enable & conn_change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.prev <= LS_J;
            cur_q.conn <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wake       = (line != cur_q.prev) | conn_change | dn_resume;
    assign conn_event = cur_q.conn;
endmodule

// File: rtl/usbsw_ctrl.sv
module usbsw_ctrl
    import usbsw_pkg::*;
#(
    parameter int unsigned IDLE_US   = 3000,
    parameter int unsigned SETTLE_US = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] line_state,
    input  logic       tick_us,
    input  logic       conn_change,
    input  logic       dn_resume,
    output logic       suspend,
    output logic       wake_ready,
    output logic       conn_event
);
    typedef struct packed {
        pwr_t st;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  idle_expired;
    logic  settle_done;
    logic  wake_seen;
    logic  idle_clear;
    logic  settle_run;

    assign idle_clear = !enable || (cur_q.st != PS_ACTIVE);
    assign settle_run = enable && (cur_q.st == PS_SETTLE);

    usbsw_idle_timer #(.IDLE_US(IDLE_US)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clear),
        .tick    (tick_us),
        .line    (line_state),
        .expired (idle_expired)
    );

    usbsw_settle_timer #(.SETTLE_US(SETTLE_US)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .tick  (tick_us),
        .done  (settle_done)
    );

    usbsw_wake_detect u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .line        (line_state),
        .conn_change (conn_change),
        .dn_resume   (dn_resume),
        .wake        (wake_seen),
        .conn_event  (conn_event)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!enable) begin
            nxt_d.st = PS_ACTIVE;
        end else begin
            unique case (cur_q.st)
                PS_ACTIVE:  if (idle_expired) nxt_d.st = PS_SUSPEND;
                PS_SUSPEND: if (wake_seen)    nxt_d.st = PS_SETTLE;
                PS_SETTLE:  if (settle_done)  nxt_d.st = PS_ACTIVE;
                default:    nxt_d.st = PS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= PS_ACTIVE;
        else        cur_q    <= nxt_d;
    end

    assign suspend    = (cur_q.st == PS_SUSPEND);
    assign wake_ready = (cur_q.st == PS_ACTIVE);
endmodule

// File: rtl/usbsw_ctrl_chk.sv
module usbsw_ctrl_chk #(
    parameter int unsigned IDLE_US     = 3000,
    parameter int unsigned RECOVERY_US = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] line_state,
    input logic       tick_us,
    input logic       conn_change,
    input logic       dn_resume,
    input logic       suspend,
    input logic       wake_ready,
    input logic       conn_event
);
    int unsigned jcnt;
    int unsigned rcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jcnt <= 0;
            rcnt <= 0;
        end else begin
            if (!enable || line_state != 2'b01) jcnt <= 0;
            else if (tick_us && jcnt <= IDLE_US) jcnt <= jcnt + 1;
            if (suspend || wake_ready) rcnt <= 0;
            else if (tick_us) rcnt <= rcnt + 1;
        end
    end

    assert_idle_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend) |-> ($past(jcnt) > IDLE_US));
    assert_line_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && line_state != $past(line_state)) |=> !suspend);
    assert_event_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && (conn_change || dn_resume)) |=> !suspend);
    assert_conn_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conn_change) |=> conn_event);
    assert_conn_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conn_event |-> $past(conn_change));
    assert_settle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(suspend) && $past(enable)) |-> !wake_ready);
    assert_ready_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_ready) |-> (!$past(suspend) || !$past(enable)));
    assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= RECOVERY_US);
    assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!suspend && wake_ready && !conn_event));
endmodule

bind usbsw_ctrl usbsw_ctrl_chk #(.IDLE_US(IDLE_US)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .line_state  (line_state),
    .tick_us     (tick_us),
    .conn_change (conn_change),
    .dn_resume   (dn_resume),
    .suspend     (suspend),
    .wake_ready  (wake_ready),
    .conn_event  (conn_event)
);

// File: tb/usbsw_ctrl_test.sv
module usbsw_ctrl_test;
    localparam int IDLE   = 20;
    localparam int SETTLE = 3;
    localparam int TDIV   = 5;
    localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [1:0] line_state = J;
    logic       tick_us = 1'b0;
    logic       conn_change = 1'b0;
    logic       dn_resume = 1'b0;
    logic       suspend, wake_ready, conn_event;

    usbsw_ctrl #(.IDLE_US(IDLE), .SETTLE_US(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line_state(line_state),
        .tick_us(tick_us), .conn_change(conn_change), .dn_resume(dn_resume),
        .suspend(suspend), .wake_ready(wake_ready), .conn_event(conn_event)
    );

    int    n_total = 0, n_pass = 0;
    string tag = "R9";
    logic  cmp_en = 1'b0;

    task automatic check(string req, logic act, logic exp, string what);
        n_total++;
        if (act !== exp) $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        else n_pass++;
    endtask

    // behavioural reference model
    int m_st = 0, m_idle = 0, m_settle = 0, m_old = 0;
    logic [1:0] m_prev = J;
    logic m_conn = 1'b0, m_wk;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idle = 0; m_settle = 0; m_prev = J; m_conn = 0;
        end else if (!enable) begin
            m_st = 0; m_idle = 0; m_settle = 0; m_prev = line_state; m_conn = 0;
        end else begin
            m_old = m_st;
            m_wk = (line_state != m_prev) || conn_change || dn_resume;
            if (m_old == 0 && m_idle > IDLE) m_st = 1;
            else if (m_old == 1 && m_wk) m_st = 2;
            else if (m_old == 2 && m_settle >= SETTLE) m_st = 0;
            if (m_old != 0 || line_state != J) m_idle = 0;
            else if (tick_us && m_idle <= IDLE) m_idle++;
            if (m_old != 2) m_settle = 0;
            else if (tick_us && m_settle < SETTLE) m_settle++;
            m_conn = conn_change;
            m_prev = line_state;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(tag, suspend, m_st == 1, "suspend");
            check(tag, wake_ready, m_st == 0, "wake_ready");
            check(tag, conn_event, m_conn, "conn_event");
        end
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % TDIV;
            tick_us = (ph == 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_suspend();
        line_state = J;
        cyc((IDLE + 4) * TDIV);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        int wait_cyc;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", suspend, 1'b0, "suspend after reset");
        check("R9", wake_ready, 1'b1, "wake_ready after reset");
        check("R9", conn_event, 1'b0, "conn_event after reset");
        cmp_en = 1'b1;

        // R1: idle stretch interrupted by SE0 and K restarts the count
        tag = "R1";
        line_state = J;   cyc(12 * TDIV);
        line_state = SE0; cyc(2);
        line_state = K;   cyc(1);
        line_state = J;   cyc(16 * TDIV);
        check("R1", suspend, 1'b0, "suspend after interrupted idle");

        // R2: enough idle time enters suspend
        tag = "R2";
        cyc(8 * TDIV);
        check("R2", suspend, 1'b1, "suspend after long idle");

        // R3: line change wakes; R6/R7 settle window
        tag = "R3";
        line_state = K;
        @(negedge clk);
        check("R3", suspend, 1'b0, "suspend after K");
        check("R6", wake_ready, 1'b0, "wake_ready during settle");
        line_state = J;
        tag = "R6";
        wait_cyc = 0;
        while (!wake_ready && wait_cyc < 100) begin @(negedge clk); wait_cyc++; end
        check("R7", wait_cyc <= (SETTLE + 1) * TDIV + 2, 1'b1, "recovery within window");
        check("R6", wake_ready, 1'b1, "wake_ready after settle");

        // R4/R5: connection change while suspended
        go_suspend();
        check("R2", suspend, 1'b1, "suspend again");
        tag = "R4";
        conn_change = 1'b1; @(negedge clk); conn_change = 1'b0;
        check("R5", conn_event, 1'b1, "conn_event while suspended");
        check("R4", suspend, 1'b0, "exit on conn_change");
        // R10: wake causes during settle do nothing extra
        tag = "R10";
        dn_resume = 1'b1; @(negedge clk); dn_resume = 1'b0;
        check("R10", suspend, 1'b0, "resume during settle");
        cyc(30);
        check("R10", wake_ready, 1'b1, "settled despite events");

        // R4: downstream resume wakes
        go_suspend();
        tag = "R4";
        dn_resume = 1'b1; @(negedge clk); dn_resume = 1'b0;
        check("R4", suspend, 1'b0, "exit on dn_resume");
        cyc(30);

        // R10: events while active
        tag = "R10";
        dn_resume = 1'b1; conn_change = 1'b1; @(negedge clk);
        dn_resume = 1'b0; conn_change = 1'b0;
        check("R10", suspend, 1'b0, "active ignores events");
        check("R5", conn_event, 1'b1, "conn_event while active");

        // R8: enable low in suspend
        go_suspend();
        tag = "R8";
        enable = 1'b0; conn_change = 1'b1; @(negedge clk); conn_change = 1'b0;
        check("R8", suspend, 1'b0, "suspend forced low");
        check("R8", wake_ready, 1'b1, "wake_ready forced high");
        check("R8", conn_event, 1'b0, "conn_event masked");
        cyc(2);
        enable = 1'b1;
        // R8: counter cleared by enable low mid-idle
        cyc(15 * TDIV);
        enable = 1'b0; cyc(1); enable = 1'b1;
        cyc(15 * TDIV);
        check("R8", suspend, 1'b0, "idle count restarted");
        cyc(10 * TDIV);
        check("R8", suspend, 1'b1, "suspend after fresh idle");
        cyc(5);

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule